// File: doc/BRIEF.md
# Vector Control State Register with Length Setting

This block holds the 64-bit vector control word of a scalar core that carries a vector extension. The word records the maximum and current vector length, the source and destination element and sub-element positions, the operand-to-shape selectors and enable mask used by index remapping, the pack and unpack ordering flags, a parallelism hint, a remap persistence flag and a vertical-first flag. Every field is decoded and driven out as its own port so that the loop and remap logic around it can read the control word without any further decoding.

Two kinds of update reach the register. A length-setting operation supplies an immediate maximum length and a requested length. The requested length comes from an immediate, a general-purpose register value or a counter value. The new length is the smaller of the request and the new maximum, and the same value is returned on a result port. A raw write loads the whole word, as a move to a special register would. A write whose contents are out of range is refused: the word keeps its value and a trap pulse is raised.

Top module: `vstate_reg`

## Requirements
- R1: After reset the control word is all zeros and `trap` is low.
- R2: Fields are numbered big-endian, with bit 0 as the word's MSB (`state_q[63]`). The layout is maxvl 0:6, vl 7:13, srcstep 14:20, dststep 21:27, dsubstep 28:29, ssubstep 30:31, the five selectors in[0] 32:33, in[1] 34:35, in[2] 36:37, out[0] 38:39 and out[1] 40:41, enable mask 42:46, reserved 47:52, pack 53, unpack 54, hint 55:61, persist 62 and vfirst 63. Each decoded output port equals its field.
- R3: A length-setting operation (`setlen_en`) with `setlen_mvl` ≤ 64 stores maxvl = `setlen_mvl` and vl = MIN(request, `setlen_mvl`). The request is `setlen_imm` when `setlen_src` is 0, `setlen_gpr` when it is 1, and `setlen_ctr` when it is 2 or 3. `setlen_rt` shows the same length, zero-extended, in the cycle the operation is presented.
- R4: A raw write (`raw_wr_en`) whose vl exceeds its maxvl stores vl truncated to maxvl. The stored vl never exceeds the stored maxvl.
- R5: A raw write with srcstep ≥ 64, dststep ≥ 64, vl > 64 or maxvl > 64, or a length-setting operation with `setlen_mvl` > 64, leaves the word unchanged. It raises `trap` for exactly the one cycle after the operation's clock edge.
- R6: A length-setting operation that changes vl or maxvl clears persist. One that changes neither keeps persist.
- R7: A length-setting operation zeroes srcstep, dststep, ssubstep and dsubstep. It leaves the selectors, enable mask, pack, unpack, hint and vfirst unchanged.
- R8: Reserved bits 47:52 always read as zero, even after a raw write of ones.
- R9: `remap_active` is high exactly when the enable mask is nonzero, whatever the selectors hold. In `f_remap_en`, bit 0 belongs to operand A, bits 1 to 3 to operands B, C and the target, and bit 4 to the address operand. `f_remap_sel[2k+1:2k]` is selector k.
- R10: When both operations are presented in one cycle, the length-setting operation takes effect and the raw write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setlen_en | input | 1 | Length-setting operation strobe |
| setlen_src | input | 2 | Request source: 0 immediate, 1 GPR, 2/3 counter |
| setlen_mvl | input | 7 | Immediate maximum length |
| setlen_imm | input | 7 | Immediate requested length |
| setlen_gpr | input | 64 | GPR requested length |
| setlen_ctr | input | 64 | Counter requested length |
| raw_wr_en | input | 1 | Whole-word write strobe |
| raw_wr_data | input | 64 | Whole-word write value |
| setlen_rt | output | 64 | Resulting length of the presented length-setting operation |
| state_q | output | 64 | Full control word |
| f_maxvl | output | 7 | Maximum length |
| f_vl | output | 7 | Current length |
| f_srcstep | output | 7 | Source element position |
| f_dststep | output | 7 | Destination element position |
| f_dsubstep | output | 2 | Destination sub-element position |
| f_ssubstep | output | 2 | Source sub-element position |
| f_remap_sel | output | 10 | Five 2-bit shape selectors |
| f_remap_en | output | 5 | Remap enable mask |
| f_pack | output | 1 | Source loop order inverted |
| f_unpack | output | 1 | Destination loop order inverted |
| f_hint | output | 7 | Parallelism hint |
| f_persist | output | 1 | Remap persistence |
| f_vfirst | output | 1 | Vertical-first mode |
| remap_active | output | 1 | Remap enabled for some operand |
| trap | output | 1 | Illegal operation pulse |

## Verification
The hardest case to reach is the persistence rule of R6. The persist bit can only be set by a raw write, and a following length-setting operation must then repeat the stored maxvl and vl exactly to show that persist is kept. The stimulus therefore writes a known word with persist set and sends a set-length with equal values before one with a changed length. It also mixes random raw words whose step and length fields sit around 64, so that both refused and truncated writes occur next to legal ones.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
   localparam int LEN_W  = 7;
   localparam int SUB_W  = 2;
   localparam int SEL_W  = 2;
   localparam int NSEL   = 5;
   localparam int ME_W   = 5;
   localparam int RSV_W  = 6;
   localparam int HINT_W = 7;
   localparam int WORD_W = 64;

   typedef struct packed {
      logic [LEN_W-1:0]  maxvl;
      logic [LEN_W-1:0]  vl;
      logic [LEN_W-1:0]  srcstep;
      logic [LEN_W-1:0]  dststep;
      logic [SUB_W-1:0]  dsubstep;
      logic [SUB_W-1:0]  ssubstep;
      logic [SEL_W-1:0]  sel_in0;
      logic [SEL_W-1:0]  sel_in1;
      logic [SEL_W-1:0]  sel_in2;
      logic [SEL_W-1:0]  sel_out0;
      logic [SEL_W-1:0]  sel_out1;
      logic [ME_W-1:0]   me;
      logic [RSV_W-1:0]  rsvd;
      logic              pack;
      logic              unpack;
      logic [HINT_W-1:0] hint;
      logic              persist;
      logic              vfirst;
   } vstate_t;

   typedef enum logic [1:0] {
      SRC_IMM  = 2'd0,
      SRC_GPR  = 2'd1,
      SRC_CTR  = 2'd2,
      SRC_CTR2 = 2'd3
   } len_src_e;
endpackage

// File: rtl/vstate_len_clamp.sv
module vstate_len_clamp
   import vstate_pkg::*;
#(
   parameter int LEN_LIMIT = 64
) (
   input  logic [1:0]        src,
   input  logic [LEN_W-1:0]  mvl,
   input  logic [LEN_W-1:0]  imm,
   input  logic [WORD_W-1:0] gpr,
   input  logic [WORD_W-1:0] ctr,
   output logic [LEN_W-1:0]  len,
   output logic [WORD_W-1:0] rt,
   output logic              mvl_bad
);
   localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(LEN_LIMIT);

   logic [WORD_W-1:0] req;
   logic [WORD_W-1:0] mvl_ext;

   always_comb begin
      unique case (len_src_e'(src))
         SRC_IMM: req = {{(WORD_W-LEN_W){1'b0}}, imm};
         SRC_GPR: req = gpr;
         default: req = ctr;
      endcase
   end

   assign mvl_ext = {{(WORD_W-LEN_W){1'b0}}, mvl};
   assign len     = (req > mvl_ext) ? mvl : req[LEN_W-1:0];
   assign rt      = {{(WORD_W-LEN_W){1'b0}}, len};
   assign mvl_bad = (mvl > LIMIT_V);
endmodule

// File: rtl/vstate_raw_check.sv
module vstate_raw_check
   import vstate_pkg::*;
#(
   parameter int LEN_LIMIT = 64
) (
   input  vstate_t wr,
   output vstate_t fixed,
   output logic    bad
);
   localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(LEN_LIMIT);

   logic step_bad;
   logic len_bad;

   assign step_bad = (wr.srcstep >= LIMIT_V) || (wr.dststep >= LIMIT_V);
   assign len_bad  = (wr.vl > LIMIT_V) || (wr.maxvl > LIMIT_V);
   assign bad      = step_bad || len_bad;

   always_comb begin
      fixed      = wr;
      fixed.rsvd = '0;
      if (wr.vl > wr.maxvl) begin
         fixed.vl = wr.maxvl;
      end
   end
endmodule

// File: rtl/vstate_decode.sv
module vstate_decode
   import vstate_pkg::*;
(
   input  vstate_t                st,
   output logic [LEN_W-1:0]       maxvl,
   output logic [LEN_W-1:0]       vl,
   output logic [LEN_W-1:0]       srcstep,
   output logic [LEN_W-1:0]       dststep,
   output logic [SUB_W-1:0]       dsubstep,
   output logic [SUB_W-1:0]       ssubstep,
   output logic [NSEL*SEL_W-1:0]  remap_sel,
   output logic [ME_W-1:0]        remap_en,
   output logic                   pack,
   output logic                   unpack,
   output logic [HINT_W-1:0]      hint,
   output logic                   persist,
   output logic                   vfirst,
   output logic                   remap_active
);
   logic [NSEL-1:0][SEL_W-1:0] sel_grp;

   assign sel_grp = {st.sel_out1, st.sel_out0, st.sel_in2, st.sel_in1, st.sel_in0};

   for (genvar k = 0; k < NSEL; k++) begin : g_sel
      assign remap_sel[k*SEL_W +: SEL_W] = sel_grp[k];
   end

   assign maxvl        = st.maxvl;
   assign vl           = st.vl;
   assign srcstep      = st.srcstep;
   assign dststep      = st.dststep;
   assign dsubstep     = st.dsubstep;
   assign ssubstep     = st.ssubstep;
   assign remap_en     = st.me;
   assign pack         = st.pack;
   assign unpack       = st.unpack;
   assign hint         = st.hint;
   assign persist      = st.persist;
   assign vfirst       = st.vfirst;
   assign remap_active = |st.me;
endmodule

// File: rtl/vstate_reg.sv
module vstate_reg
   import vstate_pkg::*;
#(
   parameter int LEN_LIMIT = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   setlen_en,
   input  logic [1:0]             setlen_src,
   input  logic [LEN_W-1:0]       setlen_mvl,
   input  logic [LEN_W-1:0]       setlen_imm,
   input  logic [WORD_W-1:0]      setlen_gpr,
   input  logic [WORD_W-1:0]      setlen_ctr,
   input  logic                   raw_wr_en,
   input  logic [WORD_W-1:0]      raw_wr_data,
   output logic [WORD_W-1:0]      setlen_rt,
   output logic [WORD_W-1:0]      state_q,
   output logic [LEN_W-1:0]       f_maxvl,
   output logic [LEN_W-1:0]       f_vl,
   output logic [LEN_W-1:0]       f_srcstep,
   output logic [LEN_W-1:0]       f_dststep,
   output logic [SUB_W-1:0]       f_dsubstep,
   output logic [SUB_W-1:0]       f_ssubstep,
   output logic [NSEL*SEL_W-1:0]  f_remap_sel,
   output logic [ME_W-1:0]        f_remap_en,
   output logic                   f_pack,
   output logic                   f_unpack,
   output logic [HINT_W-1:0]      f_hint,
   output logic                   f_persist,
   output logic                   f_vfirst,
   output logic                   remap_active,
   output logic                   trap
);
   if ($bits(vstate_t) != WORD_W) begin : g_bad_layout
      $error("vstate_t must be exactly WORD_W bits");
   end
   if (LEN_LIMIT < 1 || LEN_LIMIT >= (1 << LEN_W)) begin : g_bad_limit
      $error("LEN_LIMIT must fit in LEN_W bits");
   end

   vstate_t          st_q;
   vstate_t          st_d;
   vstate_t          raw_fixed;
   logic             raw_bad;
   logic             mvl_bad;
   logic [LEN_W-1:0] cl_len;
   logic             trap_d;

   vstate_len_clamp #(.LEN_LIMIT(LEN_LIMIT)) i_clamp (
      .src     (setlen_src),
      .mvl     (setlen_mvl),
      .imm     (setlen_imm),
      .gpr     (setlen_gpr),
      .ctr     (setlen_ctr),
      .len     (cl_len),
      .rt      (setlen_rt),
      .mvl_bad (mvl_bad)
   );

   vstate_raw_check #(.LEN_LIMIT(LEN_LIMIT)) i_raw (
      .wr    (vstate_t'(raw_wr_data)),
      .fixed (raw_fixed),
      .bad   (raw_bad)
   );

   always_comb begin
      st_d   = st_q;
      trap_d = 1'b0;
      if (setlen_en) begin
         if (mvl_bad) begin
            trap_d = 1'b1;
         end else begin
            st_d.maxvl    = setlen_mvl;
            st_d.vl       = cl_len;
            st_d.srcstep  = '0;
            st_d.dststep  = '0;
            st_d.ssubstep = '0;
            st_d.dsubstep = '0;
            if ((setlen_mvl != st_q.maxvl) || (cl_len != st_q.vl)) begin
               st_d.persist = 1'b0;
            end
         end
      end else if (raw_wr_en) begin
         if (raw_bad) begin
            trap_d = 1'b1;
         end else begin
            st_d = raw_fixed;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
         trap <= 1'b0;
      end else begin
         st_q <= st_d;
         trap <= trap_d;
      end
   end

   assign state_q = st_q;

   vstate_decode i_dec (
      .st           (st_q),
      .maxvl        (f_maxvl),
      .vl           (f_vl),
      .srcstep      (f_srcstep),
      .dststep      (f_dststep),
      .dsubstep     (f_dsubstep),
      .ssubstep     (f_ssubstep),
      .remap_sel    (f_remap_sel),
      .remap_en     (f_remap_en),
      .pack         (f_pack),
      .unpack       (f_unpack),
      .hint         (f_hint),
      .persist      (f_persist),
      .vfirst       (f_vfirst),
      .remap_active (remap_active)
   );
endmodule

// File: rtl/vstate_reg_chk.sv
module vstate_reg_chk
   import vstate_pkg::*;
#(
   parameter int LEN_LIMIT = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  setlen_en,
   input logic [LEN_W-1:0]      setlen_mvl,
   input logic [WORD_W-1:0]     state_q,
   input logic [LEN_W-1:0]      f_maxvl,
   input logic [LEN_W-1:0]      f_vl,
   input logic [LEN_W-1:0]      f_srcstep,
   input logic [LEN_W-1:0]      f_dststep,
   input logic [SUB_W-1:0]      f_dsubstep,
   input logic [SUB_W-1:0]      f_ssubstep,
   input logic [ME_W-1:0]       f_remap_en,
   input logic                  f_persist,
   input logic                  remap_active,
   input logic                  trap
);
   localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(LEN_LIMIT);

   AST_VL_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      f_vl <= f_maxvl); // R4

   AST_STEPS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (f_srcstep < LIMIT_V) && (f_dststep < LIMIT_V) && (f_maxvl <= LIMIT_V)); // R5

   AST_TRAP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> $stable(state_q)); // R5

   AST_PERSIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (setlen_en && setlen_mvl <= LIMIT_V) |=>
         (!f_persist || (f_maxvl == $past(f_maxvl) && f_vl == $past(f_vl)))); // R6

   AST_STEPS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
      (setlen_en && setlen_mvl <= LIMIT_V) |=>
         (f_srcstep == '0 && f_dststep == '0 && f_ssubstep == '0 && f_dsubstep == '0)); // R7

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[16:11] == '0); // R8

   AST_REMAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (f_remap_en == '0) |-> !remap_active); // R9
endmodule

bind vstate_reg vstate_reg_chk #(.LEN_LIMIT(LEN_LIMIT)) i_vstate_reg_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .setlen_en    (setlen_en),
   .setlen_mvl   (setlen_mvl),
   .state_q      (state_q),
   .f_maxvl      (f_maxvl),
   .f_vl         (f_vl),
   .f_srcstep    (f_srcstep),
   .f_dststep    (f_dststep),
   .f_dsubstep   (f_dsubstep),
   .f_ssubstep   (f_ssubstep),
   .f_remap_en   (f_remap_en),
   .f_persist    (f_persist),
   .remap_active (remap_active),
   .trap         (trap)
);

// File: tb/test_vstate_reg.sv
`timescale 1ns/1ps
module test_vstate_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        setlen_en = 1'b0;
   logic [1:0]  setlen_src = 2'd0;
   logic [6:0]  setlen_mvl = 7'd0;
   logic [6:0]  setlen_imm = 7'd0;
   logic [63:0] setlen_gpr = 64'd0;
   logic [63:0] setlen_ctr = 64'd0;
   logic        raw_wr_en = 1'b0;
   logic [63:0] raw_wr_data = 64'd0;
   logic [63:0] setlen_rt, state_q;
   logic [6:0]  f_maxvl, f_vl, f_srcstep, f_dststep, f_hint;
   logic [1:0]  f_dsubstep, f_ssubstep;
   logic [9:0]  f_remap_sel;
   logic [4:0]  f_remap_en;
   logic        f_pack, f_unpack, f_persist, f_vfirst, remap_active, trap;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] model_st = 64'd0;
   bit          model_trap = 1'b0;

   always #2.5 clk = ~clk;

   vstate_reg i_vstate_reg (.*);

   function automatic longint unsigned fld(logic [63:0] v, int first, int last);
      longint unsigned r = 0;
      for (int i = first; i <= last; i++) r = (r << 1) | longint'(v[63-i]);
      return r;
   endfunction

   function automatic logic [63:0] setf(logic [63:0] v, int first, int last, longint unsigned val);
      logic [63:0] o = v;
      for (int i = last; i >= first; i--) begin
         o[63-i] = val[0];
         val = val >> 1;
      end
      return o;
   endfunction

   task automatic check(string tag, longint unsigned act, longint unsigned exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_outputs(string tag);
      check({tag, " word"}, state_q, model_st);
      check("R5 trap", trap, model_trap);
      check("R2 maxvl", f_maxvl, fld(model_st, 0, 6));
      check("R2 vl", f_vl, fld(model_st, 7, 13));
      check("R2 srcstep", f_srcstep, fld(model_st, 14, 20));
      check("R2 dststep", f_dststep, fld(model_st, 21, 27));
      check("R2 dsubstep", f_dsubstep, fld(model_st, 28, 29));
      check("R2 ssubstep", f_ssubstep, fld(model_st, 30, 31));
      for (int k = 0; k < 5; k++)
         check("R9 selector", f_remap_sel[2*k +: 2], fld(model_st, 32 + 2*k, 33 + 2*k));
      check("R9 enable", f_remap_en, fld(model_st, 42, 46));
      check("R9 active", remap_active, fld(model_st, 42, 46) != 0);
      check("R2 pack", f_pack, fld(model_st, 53, 53));
      check("R2 unpack", f_unpack, fld(model_st, 54, 54));
      check("R2 hint", f_hint, fld(model_st, 55, 61));
      check("R6 persist", f_persist, fld(model_st, 62, 62));
      check("R2 vfirst", f_vfirst, fld(model_st, 63, 63));
   endtask

   // One operation per cycle: drive at the falling edge, predict, compare after the rising edge.
   task automatic op(string tag, bit sl, logic [1:0] src, int mvl, int imm,
                     logic [63:0] gpr, logic [63:0] ctr, bit wr, logic [63:0] wd);
      longint unsigned req, len;
      logic [63:0] nx;
      bit tr;
      @(negedge clk);
      setlen_en = sl; setlen_src = src; setlen_mvl = 7'(mvl); setlen_imm = 7'(imm);
      setlen_gpr = gpr; setlen_ctr = ctr; raw_wr_en = wr; raw_wr_data = wd;
      nx = model_st;
      tr = 1'b0;
      if (sl) begin
         req = (src == 2'd0) ? longint'(imm) : (src == 2'd1) ? gpr : ctr;
         len = (req > longint'(mvl)) ? longint'(mvl) : req;
         #1;
         if (mvl <= 64) check("R3 rt", setlen_rt, len);
         if (mvl > 64) tr = 1'b1;
         else begin
            if (longint'(mvl) != fld(model_st, 0, 6) || len != fld(model_st, 7, 13))
               nx = setf(nx, 62, 62, 0);
            nx = setf(nx, 0, 6, mvl);
            nx = setf(nx, 7, 13, len);
            nx = setf(nx, 14, 31, 0);
         end
      end else if (wr) begin
         if (fld(wd, 14, 20) >= 64 || fld(wd, 21, 27) >= 64 ||
             fld(wd, 7, 13) > 64 || fld(wd, 0, 6) > 64) tr = 1'b1;
         else begin
            nx = setf(wd, 47, 52, 0);
            if (fld(wd, 7, 13) > fld(wd, 0, 6)) nx = setf(nx, 7, 13, fld(wd, 0, 6));
         end
      end
      @(posedge clk);
      #1;
      model_st = nx;
      model_trap = tr;
      check_outputs(tag);
   endtask

   task automatic idle();
      op("R5 idle", 0, 0, 0, 0, 0, 0, 0, 64'd0);
   endtask

   function automatic logic [63:0] mkword(int mvl, int vl, int ss, int ds, longint unsigned rest);
      logic [63:0] w = rest;
      w = setf(w, 0, 6, mvl);
      w = setf(w, 7, 13, vl);
      w = setf(w, 14, 20, ss);
      w = setf(w, 21, 27, ds);
      return w;
   endfunction

   initial begin : watchdog
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [63:0] w;
      repeat (3) @(posedge clk);
      #1;
      check_outputs("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      // R3 immediate, GPR and counter sources
      op("R3 imm", 1, 2'd0, 20, 10, 0, 0, 0, 0);
      op("R3 gpr clamp", 1, 2'd1, 33, 0, 64'hFFFF_0000_0000_0005, 0, 0, 0);
      op("R3 ctr", 1, 2'd2, 40, 0, 0, 64'd5, 0, 0);
      op("R3 ctr alt", 1, 2'd3, 64, 0, 0, 64'd64, 0, 0);
      // R5 illegal maximum
      op("R5 mvl trap", 1, 2'd0, 65, 3, 0, 0, 0, 0);
      idle();
      // R4 truncation, R8 reserved, R9 enable-free selectors
      w = mkword(12, 50, 3, 7, 64'h0000_0000_FFC0_1FFF);
      op("R4 trunc", 0, 0, 0, 0, 0, 0, 1, w);
      w = mkword(8, 8, 1, 2, 64'h0000_0000_FFC1_F800);
      op("R8 rsvd", 0, 0, 0, 0, 0, 0, 1, w);
      w = mkword(9, 4, 0, 0, 64'h0000_0003_FFC0_0000);
      op("R9 mask zero", 0, 0, 0, 0, 0, 0, 1, w);
      // R5 illegal raw writes
      op("R5 src64", 0, 0, 0, 0, 0, 0, 1, mkword(10, 5, 64, 0, 0));
      op("R5 dst70", 0, 0, 0, 0, 0, 0, 1, mkword(10, 5, 0, 70, 0));
      op("R5 vl65", 0, 0, 0, 0, 0, 0, 1, mkword(64, 65, 0, 0, 0));
      op("R5 mvl66", 0, 0, 0, 0, 0, 0, 1, mkword(66, 1, 0, 0, 0));
      idle();
      // R6 persistence kept, then cleared; R7 other fields kept
      w = mkword(16, 9, 5, 6, 64'h0000_000F_A5AE_07FF);
      op("R6 set", 0, 0, 0, 0, 0, 0, 1, w);
      op("R6 keep R7", 1, 2'd0, 16, 9, 0, 0, 0, 0);
      op("R6 clear", 1, 2'd0, 16, 8, 0, 0, 0, 0);
      op("R6 set2", 0, 0, 0, 0, 0, 0, 1, w);
      op("R6 mvl change", 1, 2'd1, 20, 0, 64'd9, 0, 0, 0);
      // R10 both operations at once
      op("R10 priority", 1, 2'd0, 30, 30, 0, 0, 1, mkword(5, 5, 1, 1, 64'h3));
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int kind = int'($urandom_range(0, 3));
         w = mkword(int'($urandom_range(0, 70)), int'($urandom_range(0, 72)),
                    int'($urandom_range(0, 66)), int'($urandom_range(0, 66)),
                    {$urandom, $urandom});
         op("R4 R5 random", kind == 0 || kind == 3, 2'($urandom_range(0, 3)),
            int'($urandom_range(0, 70)), int'($urandom_range(0, 127)),
            {32'd0, 32'($urandom_range(0, 90))}, {$urandom, $urandom},
            kind >= 1, w);
      end
      idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule